// File: doc/BRIEF.md
# Dual-Mode Cache Access Sequencer

This block steps one lookup through an n-way set-associative cache. Each request carries a set index, a tag, a predicted way and a mode bit. The mode bit is chosen upstream from a hit/miss guess. When a hit is expected, way-predicted mode reads only the guessed way's tag and data. If that guess is wrong, the remaining ways are read in a second cycle. When a miss is expected, phased mode reads every tag of the set first and then reads only the data way that matched. A miss in either mode ends with a refill-check cycle that reads one tag and one data word of the refill candidate, which is the predicted way.

The block drives a per-way tag-enable strobe and a per-way data-enable strobe to its own behavioural tag and data arrays. At the end of each access it pulses `done` with the following results:
- hit flag
- hit way, which is the true way even after a wrong guess, so that the way predictor can be retrained
- the read data
- the number of strobe cycles
- the tag reads and data reads the access cost

A write port loads entries into the arrays.

The controller has six named states:
- `ST_IDLE`: accepts a request.
- `ST_PH_TAG`: reads all tags.
- `ST_PH_DATA`: reads the matched data way.
- `ST_WP_FIRST`: reads the predicted way.
- `ST_WP_REST`: reads every way except the predicted one.
- `ST_REFILL_CHK`: reads the refill candidate after a miss.

Transitions:
- `ST_IDLE` goes to `ST_WP_FIRST` or `ST_PH_TAG` on an accepted request, according to `req_mode`.
- `ST_PH_TAG` goes to `ST_PH_DATA` on a match and to `ST_REFILL_CHK` otherwise.
- `ST_WP_FIRST` goes back to `ST_IDLE` on a match and to `ST_WP_REST` otherwise.
- `ST_WP_REST` goes to `ST_IDLE` on a match and to `ST_REFILL_CHK` otherwise.
- `ST_PH_DATA` and `ST_REFILL_CHK` always return to `ST_IDLE`.

Top module: `cache_access_seq`

## Requirements
- R1: A request is taken only when `req_valid` is high in a cycle where `busy` is low. `busy` is high from the next cycle through the last strobe cycle. `done` pulses for exactly one cycle in the cycle after that, with `busy` low. A `req_valid` raised while `busy` is high starts no access.
- R2: `req_mode`=0 selects phased mode. Its first strobe cycle has `tag_en` all ones and `data_en` all zeros.
- R3: On a phased hit, the second strobe cycle has `data_en` one-hot on the matching way (bit w = way w) and `tag_en` zero. The results are `hit`=1, `hit_way` and `hit_data` of that way, `lat`=2, `tag_reads`=n and `data_reads`=1.
- R4: `req_mode`=1 selects way-predicted mode. Its first strobe cycle has `tag_en` and `data_en` both equal to one-hot(`req_pred`). When the predicted way matches, the results are `hit`=1, `hit_way`=`req_pred`, `lat`=1, `tag_reads`=1 and `data_reads`=1.
- R5: On a wrong way guess, the second strobe cycle enables every way except the predicted one on both strobes. If another way matches, the results are `hit`=1, `hit_way` and `hit_data` of the true way, `lat`=2, `tag_reads`=n and `data_reads`=n.
- R6: A way-predicted miss adds a third strobe cycle with both strobes one-hot(`req_pred`). The results are `hit`=0, `hit_way`=0, `hit_data`=0, `lat`=3, `tag_reads`=n+1 and `data_reads`=n+1.
- R7: A phased miss adds a second strobe cycle with both strobes one-hot(`req_pred`). The results are `hit`=0, `lat`=2, `tag_reads`=n+1 and `data_reads`=1.
- R8: `tag_reads` and `data_reads` always equal the total count of set bits in `tag_en` and `data_en` over the access's strobe cycles. `lat` equals the number of those cycles.
- R9: After reset, `busy`, `done`, `hit` and the counts are 0, and every entry is invalid, so any lookup misses.
- R10: `fill_en` writes tag, data and a valid flag into (`fill_set`, `fill_way`) at the clock edge. A later write to the same entry replaces the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 1 | 1 = way-predicted, 0 = phased |
| req_set | input | log2(SETS) | Set index |
| req_tag | input | TAG_W | Lookup tag |
| req_pred | input | log2(WAYS) | Predicted way and refill candidate |
| busy | output | 1 | Access in progress |
| tag_en | output | WAYS | Per-way tag read strobe |
| data_en | output | WAYS | Per-way data read strobe |
| done | output | 1 | Result valid pulse |
| hit | output | 1 | Access hit |
| hit_way | output | log2(WAYS) | Way that hit |
| hit_data | output | DATA_W | Data of the hit way |
| lat | output | 2 | Strobe cycles used |
| tag_reads | output | log2(WAYS+2) | Tag reads counted |
| data_reads | output | log2(WAYS+2) | Data reads counted |
| fill_en | input | 1 | Entry write strobe |
| fill_set | input | log2(SETS) | Write set |
| fill_way | input | log2(WAYS) | Write way |
| fill_tag | input | TAG_W | Tag to write |
| fill_data | input | DATA_W | Data to write |

## Verification
The bench builds the block with WAYS=4, SETS=16, TAG_W=12 and DATA_W=16. With four ways, the cost figures are distinct for every path: tag reads of 1, 4 and 5, and data reads of 1, 4 and 5. They therefore separate every path through the state machine. Sixteen sets allow a second set to be filled apart from the first. With a 2-bit way index, a guess of the last way (3) falls on the edge of the "all except predicted" mask. The strobes are summed cycle by cycle at the ports and compared with the reported counts.

// File: rtl/cas_pkg.sv
package cas_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PH_TAG,
        ST_PH_DATA,
        ST_WP_FIRST,
        ST_WP_REST,
        ST_REFILL_CHK
    } cas_state_e;
endpackage

// File: rtl/cas_tag_bank.sv
module cas_tag_bank #(
    parameter int WAYS  = 4,
    parameter int SETS  = 64,
    parameter int TAG_W = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [WAYS-1:0]  rd_en,
    output logic [WAYS-1:0]  match
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= '0;
            end else if (wr_en && wr_way == WAY_W'(w)) begin
                vld[wr_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(w)) begin
                tag_mem[wr_set] <= wr_tag;
            end
        end

        assign match[w] = rd_en[w] && vld[rd_set] && (tag_mem[rd_set] == rd_tag);
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R10
endmodule

// File: rtl/cas_data_bank.sv
module cas_data_bank #(
    parameter int WAYS   = 4,
    parameter int SETS   = 64,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAYS-1:0]   rd_en,
    input  logic [WAY_W-1:0]  sel_way,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] way_q [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] data_mem [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(w)) begin
                data_mem[wr_set] <= wr_data;
            end
        end

        assign way_q[w] = rd_en[w] ? data_mem[rd_set] : '0;
    end

    assign rd_data = way_q[sel_way];
endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
    import cas_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SET_W  = 6,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    parameter int WAY_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_mode,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [WAY_W-1:0]  req_pred,
    input  logic [WAYS-1:0]   match,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [WAYS-1:0]   tag_en,
    output logic [WAYS-1:0]   data_en,
    output logic [SET_W-1:0]  look_set,
    output logic [TAG_W-1:0]  look_tag,
    output logic [WAY_W-1:0]  sel_way,
    output logic              done,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] hit_data,
    output logic [1:0]        lat,
    output logic [CNT_W-1:0]  tag_reads,
    output logic [CNT_W-1:0]  data_reads
);
    function automatic logic [CNT_W-1:0] pc(input logic [WAYS-1:0] v);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int i = 0; i < WAYS; i++) begin
            s = s + CNT_W'(v[i]);
        end
        return s;
    endfunction

    cas_state_e        state, nxt;
    logic [SET_W-1:0]  set_q;
    logic [TAG_W-1:0]  tag_q;
    logic [WAY_W-1:0]  pred_q;
    logic [WAY_W-1:0]  way_r;
    logic [CNT_W-1:0]  tcnt, dcnt;
    logic [1:0]        lcnt;
    logic [WAYS-1:0]   pred_oh;
    logic              match_any;
    logic [WAY_W-1:0]  match_idx;
    logic              finish, fin_hit;
    logic [WAY_W-1:0]  fin_way;

    assign pred_oh   = WAYS'(1) << pred_q;
    assign match_any = |match;
    assign busy      = (state != ST_IDLE);
    assign look_set  = set_q;
    assign look_tag  = tag_q;

    always_comb begin
        match_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) match_idx = WAY_W'(i);
        end
    end

    // next state and strobes
    always_comb begin
        nxt     = state;
        tag_en  = '0;
        data_en = '0;
        finish  = 1'b0;
        fin_hit = 1'b0;
        fin_way = match_idx;
        sel_way = match_idx;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) nxt = req_mode ? ST_WP_FIRST : ST_PH_TAG;
            end
            ST_PH_TAG: begin
                tag_en = '1;
                nxt    = match_any ? ST_PH_DATA : ST_REFILL_CHK;
            end
            ST_PH_DATA: begin
                data_en = WAYS'(1) << way_r;
                sel_way = way_r;
                fin_way = way_r;
                finish  = 1'b1;
                fin_hit = 1'b1;
                nxt     = ST_IDLE;
            end
            ST_WP_FIRST: begin
                tag_en  = pred_oh;
                data_en = pred_oh;
                if (match_any) begin
                    finish  = 1'b1;
                    fin_hit = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    nxt = ST_WP_REST;
                end
            end
            ST_WP_REST: begin
                tag_en  = ~pred_oh;
                data_en = ~pred_oh;
                if (match_any) begin
                    finish  = 1'b1;
                    fin_hit = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    nxt = ST_REFILL_CHK;
                end
            end
            ST_REFILL_CHK: begin
                tag_en  = pred_oh;
                data_en = pred_oh;
                finish  = 1'b1;
                nxt     = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // request latch, accumulators and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q      <= '0;
            tag_q      <= '0;
            pred_q     <= '0;
            way_r      <= '0;
            tcnt       <= '0;
            dcnt       <= '0;
            lcnt       <= '0;
            done       <= 1'b0;
            hit        <= 1'b0;
            hit_way    <= '0;
            hit_data   <= '0;
            lat        <= '0;
            tag_reads  <= '0;
            data_reads <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (req_valid) begin
                    set_q  <= req_set;
                    tag_q  <= req_tag;
                    pred_q <= req_pred;
                end
                tcnt <= '0;
                dcnt <= '0;
                lcnt <= '0;
            end else begin
                tcnt <= tcnt + pc(tag_en);
                dcnt <= dcnt + pc(data_en);
                lcnt <= lcnt + 2'd1;
            end
            if (state == ST_PH_TAG && match_any) way_r <= match_idx;
            if (finish) begin
                done       <= 1'b1;
                hit        <= fin_hit;
                hit_way    <= fin_hit ? fin_way : '0;
                hit_data   <= fin_hit ? rd_data : '0;
                lat        <= lcnt + 2'd1;
                tag_reads  <= tcnt + pc(tag_en);
                data_reads <= dcnt + pc(data_en);
            end
        end
    end

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R1
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R1
    AST_PHASED_TAGS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(req_mode)) |-> (tag_en == '1 && data_en == '0)); // R2
    AST_PRED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(req_mode)) |-> (tag_en == data_en && $onehot(tag_en))); // R4
    AST_FAST_HIT_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat == 2'd1) |-> (hit && tag_reads == CNT_W'(1) && data_reads == CNT_W'(1))); // R4
    AST_WP_MISS_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat == 2'd3) |-> (!hit && tag_reads == CNT_W'(WAYS + 1)
                                   && data_reads == CNT_W'(WAYS + 1))); // R6
endmodule

// File: rtl/cache_access_seq.sv
module cache_access_seq #(
    parameter int WAYS   = 4,
    parameter int SETS   = 64,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int CNT_W = $clog2(WAYS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_mode,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [WAY_W-1:0]  req_pred,
    output logic              busy,
    output logic [WAYS-1:0]   tag_en,
    output logic [WAYS-1:0]   data_en,
    output logic              done,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] hit_data,
    output logic [1:0]        lat,
    output logic [CNT_W-1:0]  tag_reads,
    output logic [CNT_W-1:0]  data_reads,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    logic [WAYS-1:0]   match;
    logic [DATA_W-1:0] rd_data;
    logic [SET_W-1:0]  look_set;
    logic [TAG_W-1:0]  look_tag;
    logic [WAY_W-1:0]  sel_way;

    cas_tag_bank #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (fill_en),
        .wr_set (fill_set),
        .wr_way (fill_way),
        .wr_tag (fill_tag),
        .rd_set (look_set),
        .rd_tag (look_tag),
        .rd_en  (tag_en),
        .match  (match)
    );

    cas_data_bank #(.WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (fill_en),
        .wr_set  (fill_set),
        .wr_way  (fill_way),
        .wr_data (fill_data),
        .rd_set  (look_set),
        .rd_en   (data_en),
        .sel_way (sel_way),
        .rd_data (rd_data)
    );

    cas_ctrl #(
        .WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
        .WAY_W(WAY_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .req_set    (req_set),
        .req_tag    (req_tag),
        .req_pred   (req_pred),
        .match      (match),
        .rd_data    (rd_data),
        .busy       (busy),
        .tag_en     (tag_en),
        .data_en    (data_en),
        .look_set   (look_set),
        .look_tag   (look_tag),
        .sel_way    (sel_way),
        .done       (done),
        .hit        (hit),
        .hit_way    (hit_way),
        .hit_data   (hit_data),
        .lat        (lat),
        .tag_reads  (tag_reads),
        .data_reads (data_reads)
    );
endmodule

// File: tb/tb_cache_access_seq.sv
module tb_cache_access_seq;
    localparam int WAYS = 4, SETS = 16, TAG_W = 12, DATA_W = 16;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_mode = 0;
    logic [3:0] req_set = 0;
    logic [TAG_W-1:0] req_tag = 0;
    logic [1:0] req_pred = 0;
    logic busy, done, hit;
    logic [WAYS-1:0] tag_en, data_en;
    logic [1:0] hit_way, lat;
    logic [DATA_W-1:0] hit_data;
    logic [2:0] tag_reads, data_reads;
    logic fill_en = 0;
    logic [3:0] fill_set = 0;
    logic [1:0] fill_way = 0;
    logic [TAG_W-1:0] fill_tag = 0;
    logic [DATA_W-1:0] fill_data = 0;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    cache_access_seq #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_set(req_set), .req_tag(req_tag), .req_pred(req_pred), .busy(busy),
        .tag_en(tag_en), .data_en(data_en), .done(done), .hit(hit), .hit_way(hit_way),
        .hit_data(hit_data), .lat(lat), .tag_reads(tag_reads), .data_reads(data_reads),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_data(fill_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int s, input int w, input int t, input int d);
        @(negedge clk);
        fill_en = 1; fill_set = 4'(s); fill_way = 2'(w);
        fill_tag = TAG_W'(t); fill_data = DATA_W'(d);
        @(negedge clk);
        fill_en = 0;
    endtask

    // one access: checks first-cycle strobes, strobe sums, cycle count and results
    task automatic access(input string req, input bit mode, input int s, input int t,
                          input int pred, input bit e_hit, input int e_way, input int e_data,
                          input int e_lat, input int e_tr, input int e_dr, input bit poke);
        int cyc = 0, tsum = 0, dsum = 0;
        logic [WAYS-1:0] e_t0, e_d0;
        e_t0 = mode ? WAYS'(1) << pred : '1;
        e_d0 = mode ? WAYS'(1) << pred : '0;
        @(negedge clk);
        req_valid = 1; req_mode = mode; req_set = 4'(s);
        req_tag = TAG_W'(t); req_pred = 2'(pred);
        @(negedge clk);
        req_valid = 0;
        chk(tag_en == e_t0, req, "first tag_en", int'(tag_en), int'(e_t0));
        chk(data_en == e_d0, req, "first data_en", int'(data_en), int'(e_d0));
        while (busy && cyc < 8) begin
            if (poke && cyc == 0) begin
                req_valid = 1; req_mode = 0; req_tag = TAG_W'(12'hABC);
            end else begin
                req_valid = 0;
            end
            cyc++;
            tsum += $countones(tag_en);
            dsum += $countones(data_en);
            @(negedge clk);
        end
        req_valid = 0;
        chk(done == 1'b1, req, "done pulse", int'(done), 1);
        chk(cyc == e_lat, req, "busy cycles", cyc, e_lat);
        chk(int'(lat) == e_lat, req, "lat", int'(lat), e_lat);
        chk(int'(tag_reads) == e_tr, req, "tag_reads", int'(tag_reads), e_tr);
        chk(int'(data_reads) == e_dr, req, "data_reads", int'(data_reads), e_dr);
        chk(tsum == e_tr, "R8", "tag strobe sum", tsum, e_tr);
        chk(dsum == e_dr, "R8", "data strobe sum", dsum, e_dr);
        chk(hit == e_hit, req, "hit", int'(hit), int'(e_hit));
        if (e_hit) begin
            chk(int'(hit_way) == e_way, req, "hit_way", int'(hit_way), e_way);
            chk(int'(hit_data) == e_data, req, "hit_data", int'(hit_data), e_data);
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1", "done single / idle",
            int'({done, busy}), 0);
    endtask

    task automatic t_reset;
        chk(busy == 0, "R9", "reset busy", int'(busy), 0);
        chk(done == 0, "R9", "reset done", int'(done), 0);
        chk(hit == 0 && tag_reads == 0 && data_reads == 0, "R9", "reset results",
            int'({hit, tag_reads, data_reads}), 0);
        // any lookup misses after reset: phased miss path
        access("R9", 0, 5, 12'h102, 1, 0, 0, 0, 2, WAYS + 1, 1, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        for (int w = 0; w < WAYS; w++) fill(5, w, 12'h100 + w, 16'hA000 + w);
        fill(9, 2, 12'h055, 16'hBEEF);
        access("R3", 0, 5, 12'h102, 0, 1, 2, 16'hA002, 2, WAYS, 1, 0);
        access("R4", 1, 5, 12'h101, 1, 1, 1, 16'hA001, 1, 1, 1, 0);
        access("R5", 1, 5, 12'h103, 0, 1, 3, 16'hA003, 2, WAYS, WAYS, 0);
        access("R6", 1, 5, 12'h1FF, 2, 0, 0, 0, 3, WAYS + 1, WAYS + 1, 0);
        access("R7", 0, 9, 12'h100, 3, 0, 0, 0, 2, WAYS + 1, 1, 0);
        access("R5", 1, 9, 12'h055, 3, 1, 2, 16'hBEEF, 2, WAYS, WAYS, 0);
        access("R2", 0, 5, 12'h100, 2, 1, 0, 16'hA000, 2, WAYS, 1, 0);
        // R1: request raised while busy must not start a second access
        access("R1", 1, 5, 12'h103, 3, 1, 3, 16'hA003, 1, 1, 1, 1);
        chk(busy == 0, "R1", "no access from busy request", int'(busy), 0);
        // R10: overwrite entry
        fill(9, 2, 12'h066, 16'h1234);
        access("R10", 0, 9, 12'h055, 0, 0, 0, 0, 2, WAYS + 1, 1, 0);
        access("R10", 1, 9, 12'h066, 2, 1, 2, 16'h1234, 1, 1, 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule